// File: doc/BRIEF.md
# Unit-Element Mismatch Learner and Canceller

This block sits after a multi-bit noise-shaping converter whose feedback DAC is built from N equal unit elements driven by a thermometer-style select vector. Element-to-element mismatch adds an error term to the output word. This block learns that term for each element and removes it. Mismatch shaping stops working well when the oversampling ratio is low, so the block uses a different method. For each element it correlates the output word with that element's select history, after passing the history through a fixed three-tap filter. The filter models how a DAC error reaches the output. The products are averaged over a window of 2^M valid samples. The averaging works only if the rest of the output word is small and uncorrelated with the select pattern, so an upstream scrambler is expected to randomise the selection.

Operation is split into two phases. In PH_ACQUIRE the estimates are still zero and the output passes through unchanged. The first complete window moves the block into PH_CANCEL, where estimate refinement continues window after window. In both phases, every valid sample has the stored estimates of its selected elements subtracted from it. Two transitions exist. The window end takes PH_ACQUIRE to PH_CANCEL. A clear takes either state back to PH_ACQUIRE. Any estimate can be read through an indexed port.

Top module: `mmcal_estimator`

## Requirements
- R1: After reset, and after a clear, every element estimate reads as 0, `est_valid` is 0 and `corr_valid` is 0.
- R2: Select bit 1 counts as +1 and bit 0 as -1. The filtered weight of element i is C0·s(k) + C1·s(k-1) + C2·s(k-2). The history advances only on valid samples, and after reset or clear it starts at -1 (deselected).
- R3: A window is 2^M valid samples. M is taken from `avg_shift` on the first valid sample of each window and held for the rest of that window. Values above MAX_M are clamped to MAX_M.
- R4: At a window's last valid sample, the estimate of each element is loaded with the sum of weight × `v_in` over the window, arithmetically shifted right by M (rounded toward minus infinity). The accumulator then restarts from zero, and the estimate holds until the next window end.
- R5: `est_valid` rises on the same edge that loads the first window's estimates (transition from PH_ACQUIRE to PH_CANCEL). It stays high until reset or clear.
- R6: For each valid sample, `corr_out` = `v_in` minus the sum of the estimates of the elements whose `sel_vec` bit is 1. The subtraction uses the estimates held before that sample's edge. The result appears one cycle later, with `corr_valid` high.
- R7: A cycle with `in_valid` low changes no accumulator, estimate, window count or filter history, and gives `corr_valid` low on the next cycle.
- R8: `flush` is synchronous and overrides `in_valid`. A sample presented with it is discarded, and the state returns to R1.
- R9: `est_data` shows, combinationally, the estimate of the element addressed by `est_idx` (index 0 is `sel_vec[0]`).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| flush | input | 1 | Synchronous clear of all learned state |
| in_valid | input | 1 | Sample strobe |
| sel_vec | input | N_ELEM | Per-element DAC select bits for this sample |
| v_in | input | V_W | Signed converter output word |
| avg_shift | input | $clog2(MAX_M+1) | Window exponent M |
| est_idx | input | $clog2(N_ELEM) | Estimate read index |
| corr_valid | output | 1 | Corrected word valid |
| corr_out | output | V_W+COEF_W+2+$clog2(N_ELEM)+1 | Signed corrected word |
| est_valid | output | 1 | High in PH_CANCEL |
| est_data | output | V_W+COEF_W+2 | Signed estimate of element `est_idx` |

## Verification
A corrupted accumulator or filter history does not show at the ports while a window is open. It appears only at the next window end, as a wrong `est_data` value, and on the next valid sample that selects the affected element, as a wrong `corr_out`. A window counter that is off by one moves the rise of `est_valid` by one valid sample and changes every estimate, which is why the bench checks the rise at the exact sample. A wrong phase state shows up at once on `est_valid`.

// File: rtl/mmcal_pkg.sv
package mmcal_pkg;
    typedef enum logic {
        PH_ACQUIRE = 1'b0,
        PH_CANCEL  = 1'b1
    } phase_e;

    function automatic int shift_bits(input int max_m);
        return (max_m < 1) ? 1 : $clog2(max_m + 1);
    endfunction
endpackage

// File: rtl/mmcal_etf.sv
module mmcal_etf #(
    parameter int COEF_W = 3,
    parameter int C0 = 1,
    parameter int C1 = -2,
    parameter int C2 = 1,
    localparam int F_W = COEF_W + 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  flush,
    input  logic                  in_valid,
    input  logic                  sel_bit,
    output logic signed [F_W-1:0] weight
);
    localparam logic signed [F_W-1:0] K0 = F_W'(C0);
    localparam logic signed [F_W-1:0] K1 = F_W'(C1);
    localparam logic signed [F_W-1:0] K2 = F_W'(C2);

    logic hist1_q, hist2_q;

    function automatic logic signed [F_W-1:0] tap(input logic b, input logic signed [F_W-1:0] k);
        return b ? k : -k;
    endfunction

    // history of previous select bits; 0 stands for a deselected (-1) element
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hist1_q <= 1'b0;
            hist2_q <= 1'b0;
        end else if (flush) begin
            hist1_q <= 1'b0;
            hist2_q <= 1'b0;
        end else if (in_valid) begin
            hist1_q <= sel_bit;
            hist2_q <= hist1_q;
        end
    end

    always_comb begin
        weight = tap(sel_bit, K0) + tap(hist1_q, K1) + tap(hist2_q, K2);
    end
endmodule

// File: rtl/mmcal_corr.sv
module mmcal_corr #(
    parameter int V_W   = 12,
    parameter int F_W   = 5,
    parameter int MAX_M = 8,
    parameter int SHW   = 4,
    localparam int EST_W = V_W + F_W,
    localparam int ACC_W = EST_W + MAX_M
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    flush,
    input  logic                    in_valid,
    input  logic                    win_end,
    input  logic [SHW-1:0]          m_eff,
    input  logic signed [F_W-1:0]   weight,
    input  logic signed [V_W-1:0]   v_in,
    output logic signed [EST_W-1:0] est_q
);
    logic signed [EST_W-1:0] wx, vx, prod;
    logic signed [ACC_W-1:0] acc_q, sum;

    always_comb begin
        wx   = EST_W'(weight);
        vx   = EST_W'(v_in);
        prod = wx * vx;
        sum  = acc_q + ACC_W'(prod);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
            est_q <= '0;
        end else if (flush) begin
            acc_q <= '0;
            est_q <= '0;
        end else if (in_valid) begin
            if (win_end) begin
                est_q <= EST_W'(sum >>> m_eff);
                acc_q <= '0;
            end else begin
                acc_q <= sum;
            end
        end
    end
endmodule

// File: rtl/mmcal_ctrl.sv
module mmcal_ctrl #(
    parameter int MAX_M = 8,
    localparam int SHW   = mmcal_pkg::shift_bits(MAX_M),
    localparam int CNT_W = MAX_M + 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           flush,
    input  logic           in_valid,
    input  logic [SHW-1:0] avg_shift,
    output logic           win_end,
    output logic [SHW-1:0] m_eff,
    output logic           est_valid
);
    import mmcal_pkg::*;

    phase_e            state_q, state_d;
    logic [CNT_W-1:0]  cnt_q;
    logic [SHW-1:0]    m_cur_q, m_req;
    logic              first_smp, last_smp, take;

    always_comb begin
        m_req     = (avg_shift > SHW'(MAX_M)) ? SHW'(MAX_M) : avg_shift;
        first_smp = (cnt_q == '0);
        m_eff     = first_smp ? m_req : m_cur_q;
        last_smp  = (cnt_q == ((CNT_W'(1) << m_eff) - CNT_W'(1)));
        take      = in_valid && !flush;
        win_end   = take && last_smp;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            m_cur_q <= '0;
        end else if (flush) begin
            cnt_q   <= '0;
            m_cur_q <= '0;
        end else if (in_valid) begin
            cnt_q <= win_end ? '0 : cnt_q + CNT_W'(1);
            if (first_smp) m_cur_q <= m_req;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PH_ACQUIRE;
        else        state_q <= state_d;
    end

    // transitions: window end (acquire -> cancel), clear (any -> acquire)
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PH_ACQUIRE: if (win_end) state_d = PH_CANCEL;
            PH_CANCEL:  state_d = PH_CANCEL;
        endcase
        if (flush) state_d = PH_ACQUIRE;
    end

    // outputs
    always_comb begin
        unique case (state_q)
            PH_ACQUIRE: est_valid = 1'b0;
            PH_CANCEL:  est_valid = 1'b1;
        endcase
    end
endmodule

// File: rtl/mmcal_estimator.sv
module mmcal_estimator #(
    parameter int N_ELEM = 8,
    parameter int V_W    = 12,
    parameter int MAX_M  = 8,
    parameter int COEF_W = 3,
    parameter int ETF_C0 = 1,
    parameter int ETF_C1 = -2,
    parameter int ETF_C2 = 1,
    localparam int SHW   = mmcal_pkg::shift_bits(MAX_M),
    localparam int IDX_W = (N_ELEM > 1) ? $clog2(N_ELEM) : 1,
    localparam int F_W   = COEF_W + 2,
    localparam int EST_W = V_W + F_W,
    localparam int COR_W = EST_W + IDX_W + 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    flush,
    input  logic                    in_valid,
    input  logic [N_ELEM-1:0]       sel_vec,
    input  logic signed [V_W-1:0]   v_in,
    input  logic [SHW-1:0]          avg_shift,
    input  logic [IDX_W-1:0]        est_idx,
    output logic                    corr_valid,
    output logic signed [COR_W-1:0] corr_out,
    output logic                    est_valid,
    output logic signed [EST_W-1:0] est_data
);
    logic                    win_end;
    logic [SHW-1:0]          m_eff;
    logic signed [EST_W-1:0] est_arr [N_ELEM];
    logic [N_ELEM*EST_W-1:0] est_flat;
    logic signed [COR_W-1:0] cor_sum;

    mmcal_ctrl #(.MAX_M(MAX_M)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .flush(flush), .in_valid(in_valid),
        .avg_shift(avg_shift), .win_end(win_end), .m_eff(m_eff),
        .est_valid(est_valid)
    );

    for (genvar gi = 0; gi < N_ELEM; gi++) begin : g_elem
        logic signed [F_W-1:0] weight;

        mmcal_etf #(.COEF_W(COEF_W), .C0(ETF_C0), .C1(ETF_C1), .C2(ETF_C2)) u_etf (
            .clk(clk), .rst_n(rst_n), .flush(flush), .in_valid(in_valid),
            .sel_bit(sel_vec[gi]), .weight(weight)
        );

        mmcal_corr #(.V_W(V_W), .F_W(F_W), .MAX_M(MAX_M), .SHW(SHW)) u_corr (
            .clk(clk), .rst_n(rst_n), .flush(flush), .in_valid(in_valid),
            .win_end(win_end), .m_eff(m_eff), .weight(weight), .v_in(v_in),
            .est_q(est_arr[gi])
        );

        assign est_flat[gi*EST_W +: EST_W] = est_arr[gi];
    end

    // subtract the held estimates of every element selected in this sample
    always_comb begin
        cor_sum = COR_W'(v_in);
        for (int i = 0; i < N_ELEM; i++) begin
            if (sel_vec[i]) cor_sum = cor_sum - COR_W'(est_arr[i]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            corr_valid <= 1'b0;
            corr_out   <= '0;
        end else begin
            corr_valid <= in_valid && !flush;
            if (in_valid && !flush) corr_out <= cor_sum;
        end
    end

    assign est_data = est_arr[est_idx];
endmodule

// File: rtl/mmcal_estimator_chk.sv
module mmcal_estimator_chk #(
    parameter int V_W    = 12,
    parameter int COR_W  = 21,
    parameter int FLAT_W = 136
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    flush,
    input logic                    in_valid,
    input logic signed [V_W-1:0]   v_in,
    input logic                    corr_valid,
    input logic signed [COR_W-1:0] corr_out,
    input logic                    est_valid,
    input logic [FLAT_W-1:0]       est_flat
);
    assert_clear_wipes_R8: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (est_flat == '0) && !est_valid && !corr_valid);

    assert_idle_no_effect_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_valid && !flush) |=> $stable(est_flat) && !corr_valid);

    assert_corr_valid_follows_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !flush) |=> corr_valid);

    assert_passthrough_acquire_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !flush && !est_valid) |=> corr_out == COR_W'($past(v_in)));

    assert_phase_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (est_valid && !flush) |=> est_valid);

    assert_phase_entry_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(est_valid) |-> $past(in_valid && !flush));

    assert_est_changes_on_sample_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(est_flat) |-> $past(in_valid || flush));
endmodule

bind mmcal_estimator mmcal_estimator_chk #(
    .V_W(V_W), .COR_W(COR_W), .FLAT_W(N_ELEM*EST_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .flush(flush), .in_valid(in_valid), .v_in(v_in),
    .corr_valid(corr_valid), .corr_out(corr_out), .est_valid(est_valid),
    .est_flat(est_flat)
);

// File: tb/mmcal_estimator_test.sv
module mmcal_estimator_test;
    localparam int N = 8;
    localparam int VW = 12;
    localparam int MAXM = 8;
    localparam int CW = 3;
    localparam int K0 = 1;
    localparam int K1 = -2;
    localparam int K2 = 1;
    localparam int SHW = 4;
    localparam int EW = VW + CW + 2;
    localparam int CRW = EW + 3 + 1;

    // stimulus vectors: {sel[7:0], v[11:0]}
    localparam logic [19:0] STIM [16] = '{
        {8'hA5, 12'h064}, {8'h3C, 12'hED4}, {8'hF0, 12'h1F4}, {8'h0F, 12'hF38},
        {8'h81, 12'h7FF}, {8'h7E, 12'h800}, {8'h55, 12'h0C8}, {8'hAA, 12'hFFF},
        {8'h00, 12'h3E8}, {8'hFF, 12'hC18}, {8'h96, 12'h001}, {8'h69, 12'h2BC},
        {8'hC3, 12'hE0C}, {8'h18, 12'h12C}, {8'hE7, 12'hF9C}, {8'h24, 12'h5DC}
    };

    logic clk = 0, rst_n = 0, flush = 0, in_valid = 0;
    logic [N-1:0] sel_vec = '0;
    logic signed [VW-1:0] v_in = '0;
    logic [SHW-1:0] avg_shift = '0;
    logic [2:0] est_idx = '0;
    logic corr_valid, est_valid;
    logic signed [CRW-1:0] corr_out;
    logic signed [EW-1:0] est_data;

    int n_chk = 0, n_fail = 0;
    bit finished = 0;

    bit mh1 [N];
    bit mh2 [N];
    longint macc [N];
    longint mest [N];
    int mcnt = 0, mcur = 0;
    bit mestv = 0;

    always #10 clk = ~clk;

    mmcal_estimator #(.N_ELEM(N), .V_W(VW), .MAX_M(MAXM), .COEF_W(CW),
                      .ETF_C0(K0), .ETF_C1(K1), .ETF_C2(K2)) uut (
        .clk(clk), .rst_n(rst_n), .flush(flush), .in_valid(in_valid),
        .sel_vec(sel_vec), .v_in(v_in), .avg_shift(avg_shift), .est_idx(est_idx),
        .corr_valid(corr_valid), .corr_out(corr_out), .est_valid(est_valid),
        .est_data(est_data)
    );

    task automatic chk(input string req, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic mdl_clear();
        for (int i = 0; i < N; i++) begin
            mh1[i] = 0; mh2[i] = 0; macc[i] = 0; mest[i] = 0;
        end
        mcnt = 0; mcur = 0; mestv = 0;
    endtask

    // requirement-level model of one clock edge
    task automatic mdl(input bit vld, input bit fl, input logic [N-1:0] sel,
                       input longint v, input int sh, output bit ev, output longint ec);
        int m;
        bit last;
        longint s0, s1, s2, w;
        ev = 0; ec = 0;
        if (fl) begin mdl_clear(); return; end
        if (!vld) return;
        ev = 1; ec = v;
        for (int i = 0; i < N; i++) if (sel[i]) ec -= mest[i];
        m = (mcnt == 0) ? ((sh > MAXM) ? MAXM : sh) : mcur;
        if (mcnt == 0) mcur = m;
        last = (mcnt == (1 << m) - 1);
        for (int i = 0; i < N; i++) begin
            s0 = sel[i] ? 1 : -1; s1 = mh1[i] ? 1 : -1; s2 = mh2[i] ? 1 : -1;
            w = K0 * s0 + K1 * s1 + K2 * s2;
            macc[i] += w * v;
            if (last) begin mest[i] = macc[i] >>> m; macc[i] = 0; end
            mh2[i] = mh1[i]; mh1[i] = sel[i];
        end
        if (last) begin mcnt = 0; mestv = 1; end
        else mcnt++;
    endtask

    // called at a falling edge; checks at the next falling edge
    task automatic drive(input bit vld, input bit fl, input logic [N-1:0] sel,
                         input int v, input int sh, input string tag);
        bit ev;
        longint ec;
        in_valid = vld; flush = fl; sel_vec = sel; v_in = VW'(v); avg_shift = SHW'(sh);
        mdl(vld, fl, sel, longint'(v), sh, ev, ec);
        @(posedge clk);
        @(negedge clk);
        in_valid = 0; flush = 0;
        chk({tag, " corr_valid"}, longint'(corr_valid), longint'(ev));
        if (ev) chk({tag, " corr_out"}, longint'(corr_out), ec);
        chk("R5 est_valid", longint'(est_valid), longint'(mestv));
    endtask

    task automatic check_ests(input string tag);
        for (int i = 0; i < N; i++) begin
            est_idx = 3'(i);
            #1;
            chk(tag, longint'(est_data), mest[i]);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
        end
    end

    initial begin
        mdl_clear();
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 corr_valid", longint'(corr_valid), 0);
        chk("R1 est_valid", longint'(est_valid), 0);
        check_ests("R1 R9 est after reset");
        rst_n = 1;
        @(negedge clk);

        // table walk, windows of 4, idle cycles mixed in (R7)
        for (int k = 0; k < 16; k++) begin
            drive(1, 0, STIM[k][19:12], int'($signed(STIM[k][11:0])), 2, "R6");
            if (k % 3 == 2) drive(0, 0, 8'hFF, 2047, 7, "R7");
            if (k % 4 == 3) check_ests("R2 R4 R9 window estimate");
        end

        // R8: clear mid-window with a valid sample present
        drive(1, 0, 8'h5A, 700, 2, "R6");
        drive(1, 0, 8'hC3, -900, 2, "R6");
        drive(1, 1, 8'hFF, 1500, 2, "R8");
        chk("R8 est_valid after clear", longint'(est_valid), 0);
        check_ests("R1 R8 est after clear");

        // R3: exponent latched on the first sample of a window
        drive(1, 0, 8'h99, 333, 1, "R3");
        drive(1, 0, 8'h66, -444, 3, "R3");
        chk("R3 window of two", longint'(est_valid), 1);
        check_ests("R3 R4 est after short window");

        // R3: clamp of an oversized exponent to MAX_M
        drive(0, 1, 8'h00, 0, 0, "R8");
        for (int k = 0; k < 256; k++) begin
            drive(1, 0, 8'((k * 37 + 11) % 256), (k * 53) % 4000 - 2000, 15, "R3");
            if (k == 254) chk("R3 still acquiring at 255", longint'(est_valid), 0);
        end
        chk("R3 clamped window done", longint'(est_valid), 1);
        check_ests("R3 R4 est after long window");

        // R6: correction with learned estimates
        drive(1, 0, 8'hFF, 100, 15, "R6");
        drive(1, 0, 8'h01, -100, 15, "R6");
        drive(1, 0, 8'h80, 0, 15, "R6");

        finished = 1;
        summary();
    end
endmodule